// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block picks one interrupt out of twenty-eight fixed sources and presents it to a processor core. Three sources are external level requests with hard-wired priorities. The other twenty-five belong to on-chip peripherals, and their priorities come from 4-bit fields in three software-written priority registers. Several peripheral sources can share one field. Each source also has an enable bit, held in two enable registers.

The arbitration is combinational. It works from the registered configuration, the peripheral pending lines and the core's mask level and block bit. The output is a request flag, the winning priority and a 12-bit event code that identifies the source. The block does not clear pending flags. A peripheral holds its line until its handler services it, and the request stays up for as long as a qualifying line is held. There is no handshake at this edge: the core samples the request when it is able to take it. Vectoring and context saving belong to the core.

Top module: `prio_intc`

## Requirements
- R1: After reset, offsets 0x00, 0x04, 0x08 and 0x0C read 0x0000, offset 0x10 reads 0xFFFF, offset 0x14 reads 0x0FFF, and no request is raised.
- R2: Priority registers are at offsets 0x04 (A), 0x08 (B) and 0x0C (C). Field n of each register is bits 4n+3..4n. Source index i is bit i of `pend_i`. The index-to-field map is: 3:C0, 4:C3, 5-9:C2, 10:A3, 11:A2, 12-13:A1, 14-16:A0, 17-20:B1, 21-24:C1, 25:B3, 26:B2, 27:A2.
- R3: Sources 0, 1 and 2 have the fixed priorities 6, 4 and 2, and the codes 0x320, 0x360 and 0x3A0.
- R4: A request is raised only when the winning priority is strictly above `mask_i`. A source at priority 0 is therefore never requested.
- R5: While `block_i` is high, `irq_req_o` is low.
- R6: Among qualifying sources of equal priority, the one with the larger index wins.
- R7: A source whose enable bit is 0 takes no part in arbitration. Sources 0-15 map to bits 15:0 of offset 0x10, and sources 16-27 map to bits 11:0 of offset 0x14.
- R8: A register write lands at the clock edge on which `wr_en_i` is high and affects arbitration and `rd_data_o` from the next cycle. Offset 0x00 is a plain 16-bit control register that reads back what was written.
- R9: The winner is the pending, enabled source of highest priority. `irq_level_o` and `irq_code_o` give its priority and code while the request is raised, and are 0 otherwise. The codes are: indices 3-9 at 0x600+0x20·(i−3), indices 10-20 at 0x400+0x20·(i−10), indices 21-24 at 0x700+0x20·(i−21), and indices 25-27 at 0x560+0x20·(i−25).
- R10: The request stays raised while its pending line, the mask and the block bit are held. The block never drops a pending source by itself.
- R11: Writes to unmapped offsets (0x18, 0x1C, unaligned offsets) change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte offset, used for both write and read |
| wdata_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data for `addr_i` (combinational) |
| pend_i | input | 28 | Pending level for each source |
| mask_i | input | 4 | Core's current interrupt mask level |
| block_i | input | 1 | Core's global block bit |
| irq_req_o | output | 1 | Interrupt request |
| irq_level_o | output | 4 | Priority of the requested source |
| irq_code_o | output | 12 | Event code of the requested source |

## Verification
The bench builds the block with its default parameters: 28 sources, 4-bit priorities and 16-bit registers. This puts every source-to-field mapping, both enable registers and the full 0-15 mask range within reach. A behavioural model predicts the request, level, code and read data every cycle. Directed phases cover each shared field, tie-breaking among the five DMA sources, and priority-0 sources. A long random phase mixes sparse pending patterns with writes to mapped and unmapped offsets.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int NUM_SRC = 28;
  localparam int LVL_W   = 4;
  localparam int CODE_W  = 12;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 5;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_PRI_A = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_PRI_B = 5'h08;
  localparam logic [ADDR_W-1:0] ADR_PRI_C = 5'h0C;
  localparam logic [ADDR_W-1:0] ADR_EN_LO = 5'h10;
  localparam logic [ADDR_W-1:0] ADR_EN_HI = 5'h14;

  typedef enum logic [1:0] {PSEL_FIXED, PSEL_A, PSEL_B, PSEL_C} psel_e;

  typedef struct packed {
    psel_e             sel;
    logic [1:0]        field;
    logic [LVL_W-1:0]  fixed_lvl;
    logic [CODE_W-1:0] code;
  } src_cfg_t;

  // Static description of each source, indexed by its position in pend_i.
  function automatic src_cfg_t src_cfg(input int idx);
    src_cfg_t c;
    c = '{sel: PSEL_FIXED, field: 2'd0, fixed_lvl: '0, code: '0};
    case (idx)
      0:  c = '{PSEL_FIXED, 2'd0, 4'd6, 12'h320};
      1:  c = '{PSEL_FIXED, 2'd0, 4'd4, 12'h360};
      2:  c = '{PSEL_FIXED, 2'd0, 4'd2, 12'h3A0};
      3:  c = '{PSEL_C, 2'd0, 4'd0, 12'h600};
      4:  c = '{PSEL_C, 2'd3, 4'd0, 12'h620};
      5:  c = '{PSEL_C, 2'd2, 4'd0, 12'h640};
      6:  c = '{PSEL_C, 2'd2, 4'd0, 12'h660};
      7:  c = '{PSEL_C, 2'd2, 4'd0, 12'h680};
      8:  c = '{PSEL_C, 2'd2, 4'd0, 12'h6A0};
      9:  c = '{PSEL_C, 2'd2, 4'd0, 12'h6C0};
      10: c = '{PSEL_A, 2'd3, 4'd0, 12'h400};
      11: c = '{PSEL_A, 2'd2, 4'd0, 12'h420};
      12: c = '{PSEL_A, 2'd1, 4'd0, 12'h440};
      13: c = '{PSEL_A, 2'd1, 4'd0, 12'h460};
      14: c = '{PSEL_A, 2'd0, 4'd0, 12'h480};
      15: c = '{PSEL_A, 2'd0, 4'd0, 12'h4A0};
      16: c = '{PSEL_A, 2'd0, 4'd0, 12'h4C0};
      17: c = '{PSEL_B, 2'd1, 4'd0, 12'h4E0};
      18: c = '{PSEL_B, 2'd1, 4'd0, 12'h500};
      19: c = '{PSEL_B, 2'd1, 4'd0, 12'h520};
      20: c = '{PSEL_B, 2'd1, 4'd0, 12'h540};
      21: c = '{PSEL_C, 2'd1, 4'd0, 12'h700};
      22: c = '{PSEL_C, 2'd1, 4'd0, 12'h720};
      23: c = '{PSEL_C, 2'd1, 4'd0, 12'h740};
      24: c = '{PSEL_C, 2'd1, 4'd0, 12'h760};
      25: c = '{PSEL_B, 2'd3, 4'd0, 12'h560};
      26: c = '{PSEL_B, 2'd2, 4'd0, 12'h580};
      27: c = '{PSEL_A, 2'd2, 4'd0, 12'h5A0};
      default: c = '{PSEL_FIXED, 2'd0, 4'd0, 12'h000};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
  import prio_intc_pkg::*;
#(
  parameter int P_SRC  = NUM_SRC,
  parameter int P_REGW = REG_W,
  parameter int P_ADRW = ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [P_ADRW-1:0] addr_i,
  input  logic [P_REGW-1:0] wdata_i,
  output logic [P_REGW-1:0] rd_data_o,
  output logic [P_REGW-1:0] pri_a_o,
  output logic [P_REGW-1:0] pri_b_o,
  output logic [P_REGW-1:0] pri_c_o,
  output logic [P_SRC-1:0]  en_o
);
  localparam int HI_W = P_SRC - P_REGW;

  logic [P_REGW-1:0] ctrl_q, pri_a_q, pri_b_q, pri_c_q;
  logic [P_SRC-1:0]  en_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q  <= '0;
      pri_a_q <= '0;
      pri_b_q <= '0;
      pri_c_q <= '0;
      en_q    <= '1;
    end else if (wr_en_i) begin
      case (addr_i)
        ADR_CTRL:  ctrl_q  <= wdata_i;
        ADR_PRI_A: pri_a_q <= wdata_i;
        ADR_PRI_B: pri_b_q <= wdata_i;
        ADR_PRI_C: pri_c_q <= wdata_i;
        ADR_EN_LO: en_q[P_REGW-1:0] <= wdata_i;
        ADR_EN_HI: en_q[P_SRC-1:P_REGW] <= wdata_i[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      ADR_CTRL:  rd_data_o = ctrl_q;
      ADR_PRI_A: rd_data_o = pri_a_q;
      ADR_PRI_B: rd_data_o = pri_b_q;
      ADR_PRI_C: rd_data_o = pri_c_q;
      ADR_EN_LO: rd_data_o = en_q[P_REGW-1:0];
      ADR_EN_HI: rd_data_o = {{(P_REGW-HI_W){1'b0}}, en_q[P_SRC-1:P_REGW]};
      default:   rd_data_o = '0;
    endcase
  end

  assign pri_a_o = pri_a_q;
  assign pri_b_o = pri_b_q;
  assign pri_c_o = pri_c_q;
  assign en_o    = en_q;
endmodule

// File: rtl/prio_intc_levels.sv
module prio_intc_levels
  import prio_intc_pkg::*;
#(
  parameter int P_SRC  = NUM_SRC,
  parameter int P_LVLW = LVL_W,
  parameter int P_REGW = REG_W
) (
  input  logic [P_REGW-1:0]             pri_a_i,
  input  logic [P_REGW-1:0]             pri_b_i,
  input  logic [P_REGW-1:0]             pri_c_i,
  output logic [P_SRC-1:0][P_LVLW-1:0]  lvl_o
);
  for (genvar g = 0; g < P_SRC; g++) begin : g_src
    localparam src_cfg_t CFG = src_cfg(g);
    localparam int LO = P_LVLW * int'(CFG.field);
    if (CFG.sel == PSEL_FIXED) begin : g_fix
      assign lvl_o[g] = CFG.fixed_lvl;
    end else if (CFG.sel == PSEL_A) begin : g_a
      assign lvl_o[g] = pri_a_i[LO +: P_LVLW];
    end else if (CFG.sel == PSEL_B) begin : g_b
      assign lvl_o[g] = pri_b_i[LO +: P_LVLW];
    end else begin : g_c
      assign lvl_o[g] = pri_c_i[LO +: P_LVLW];
    end
  end
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int P_SRC  = NUM_SRC,
  parameter int P_LVLW = LVL_W,
  localparam int IDX_W = $clog2(P_SRC)
) (
  input  logic [P_SRC-1:0]             cand_i,
  input  logic [P_SRC-1:0][P_LVLW-1:0] lvl_i,
  output logic                         found_o,
  output logic [IDX_W-1:0]             idx_o,
  output logic [P_LVLW-1:0]            lvl_o
);
  // Scan from low index up; ">=" lets a later source take an equal level.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int i = 0; i < P_SRC; i++) begin
      if (cand_i[i] && (!found_o || lvl_i[i] >= lvl_o)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        lvl_o   = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int P_SRC   = NUM_SRC,
  parameter int P_LVLW  = LVL_W,
  parameter int P_CODEW = CODE_W,
  parameter int P_REGW  = REG_W,
  parameter int P_ADRW  = ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               wr_en_i,
  input  logic [P_ADRW-1:0]  addr_i,
  input  logic [P_REGW-1:0]  wdata_i,
  output logic [P_REGW-1:0]  rd_data_o,
  input  logic [P_SRC-1:0]   pend_i,
  input  logic [P_LVLW-1:0]  mask_i,
  input  logic               block_i,
  output logic               irq_req_o,
  output logic [P_LVLW-1:0]  irq_level_o,
  output logic [P_CODEW-1:0] irq_code_o
);
  localparam int IDX_W = $clog2(P_SRC);

  logic [P_REGW-1:0]             pri_a, pri_b, pri_c;
  logic [P_SRC-1:0]              en;
  logic [P_SRC-1:0][P_LVLW-1:0]  lvl;
  logic                          found;
  logic [IDX_W-1:0]              win_idx;
  logic [P_LVLW-1:0]             win_lvl;
  logic [P_CODEW-1:0]            win_code;

  prio_intc_regs #(.P_SRC(P_SRC), .P_REGW(P_REGW), .P_ADRW(P_ADRW)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rd_data_o(rd_data_o), .pri_a_o(pri_a),
    .pri_b_o(pri_b), .pri_c_o(pri_c), .en_o(en)
  );

  prio_intc_levels #(.P_SRC(P_SRC), .P_LVLW(P_LVLW), .P_REGW(P_REGW)) u_lvls (
    .pri_a_i(pri_a), .pri_b_i(pri_b), .pri_c_i(pri_c), .lvl_o(lvl)
  );

  prio_intc_arb #(.P_SRC(P_SRC), .P_LVLW(P_LVLW)) u_arb (
    .cand_i(pend_i & en), .lvl_i(lvl), .found_o(found),
    .idx_o(win_idx), .lvl_o(win_lvl)
  );

  always_comb begin
    src_cfg_t c;
    c = src_cfg(int'(win_idx));
    win_code = c.code;
  end

  always_comb begin
    irq_req_o   = found && (win_lvl > mask_i) && !block_i;
    irq_level_o = irq_req_o ? win_lvl  : '0;
    irq_code_o  = irq_req_o ? win_code : '0;
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int P_SRC = 28, P_LVLW = 4, P_CODEW = 12, P_REGW = 16, P_ADRW = 5
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic               wr_en_i,
  input logic [P_ADRW-1:0]  addr_i,
  input logic [P_REGW-1:0]  rd_data_o,
  input logic [P_SRC-1:0]   pend_i,
  input logic [P_LVLW-1:0]  mask_i,
  input logic               block_i,
  input logic               irq_req_o,
  input logic [P_LVLW-1:0]  irq_level_o,
  input logic [P_CODEW-1:0] irq_code_o
);
  AST_BLOCK_SUPPRESS: assert property (@(posedge clk_i) disable iff (rst_i)
    block_i |-> !irq_req_o); // R5
  AST_ABOVE_MASK: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_req_o |-> (irq_level_o > mask_i)); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    !irq_req_o |-> (irq_code_o == '0 && irq_level_o == '0)); // R9
  AST_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_req_o |-> (pend_i != '0)); // R7
  AST_READ_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$past(wr_en_i) && addr_i == $past(addr_i))
      |-> rd_data_o == $past(rd_data_o)); // R8
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_req_o && !wr_en_i) |=>
      (irq_req_o || !$stable(pend_i) || !$stable(mask_i) || !$stable(block_i))); // R10
endmodule

bind prio_intc prio_intc_chk #(
  .P_SRC(P_SRC), .P_LVLW(P_LVLW), .P_CODEW(P_CODEW), .P_REGW(P_REGW), .P_ADRW(P_ADRW)
) u_chk (.*);

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
  logic        clk_i = 0;
  logic        rst_i = 1;
  logic        wr_en_i = 0;
  logic [4:0]  addr_i = 0;
  logic [15:0] wdata_i = 0;
  logic [15:0] rd_data_o;
  logic [27:0] pend_i = 0;
  logic [3:0]  mask_i = 0;
  logic        block_i = 0;
  logic        irq_req_o;
  logic [3:0]  irq_level_o;
  logic [11:0] irq_code_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  prio_intc u_dut (.*);

  // Behavioural model state
  logic [15:0] m_ctrl, m_a, m_b, m_c;
  logic [27:0] m_en;

  always @(posedge clk_i) begin
    if (rst_i) begin
      m_ctrl = 0; m_a = 0; m_b = 0; m_c = 0; m_en = '1;
    end else if (wr_en_i) begin
      if (addr_i == 5'h00) m_ctrl = wdata_i;
      else if (addr_i == 5'h04) m_a = wdata_i;
      else if (addr_i == 5'h08) m_b = wdata_i;
      else if (addr_i == 5'h0C) m_c = wdata_i;
      else if (addr_i == 5'h10) m_en[15:0] = wdata_i;
      else if (addr_i == 5'h14) m_en[27:16] = wdata_i[11:0];
    end
  end

  function automatic int m_lvl(int i);
    if (i == 0) return 6;
    if (i == 1) return 4;
    if (i == 2) return 2;
    if (i == 3) return m_c[3:0];
    if (i == 4) return m_c[15:12];
    if (i <= 9) return m_c[11:8];
    if (i == 10) return m_a[15:12];
    if (i == 11 || i == 27) return m_a[11:8];
    if (i <= 13) return m_a[7:4];
    if (i <= 16) return m_a[3:0];
    if (i <= 20) return m_b[7:4];
    if (i <= 24) return m_c[7:4];
    if (i == 25) return m_b[15:12];
    return m_b[11:8];
  endfunction

  function automatic int m_code(int i);
    if (i <= 2) return 'h320 + 'h40 * i;
    if (i <= 9) return 'h600 + 'h20 * (i - 3);
    if (i <= 20) return 'h400 + 'h20 * (i - 10);
    if (i <= 24) return 'h700 + 'h20 * (i - 21);
    return 'h560 + 'h20 * (i - 25);
  endfunction

  function automatic int m_read(int a);
    case (a)
      'h00: return m_ctrl;
      'h04: return m_a;
      'h08: return m_b;
      'h0C: return m_c;
      'h10: return m_en[15:0];
      'h14: return {4'h0, m_en[27:16]};
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk_i) begin
    #2;
    if (!rst_i && !done) begin
      int best, bl, er, el, ec;
      best = -1; bl = 0;
      for (int i = 0; i < 28; i++)
        if (pend_i[i] && m_en[i] && (best < 0 || m_lvl(i) >= bl)) begin
          best = i; bl = m_lvl(i);
        end
      er = (best >= 0 && bl > int'(mask_i) && !block_i) ? 1 : 0;
      el = er ? bl : 0;
      ec = er ? m_code(best) : 0;
      chk("R9 model req", int'(irq_req_o), er);
      chk("R9 model level", int'(irq_level_o), el);
      chk("R9 model code", int'(irq_code_o), ec);
      chk("R8 model read", int'(rd_data_o), m_read(int'(addr_i)));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk_i);
    wr_en_i = 1; addr_i = a[4:0]; wdata_i = d[15:0];
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic drive(logic [27:0] p, int m, bit b);
    @(negedge clk_i);
    pend_i = p; mask_i = m[3:0]; block_i = b;
    #3;
  endtask

  task automatic rd(string tag, int a, int exp);
    @(negedge clk_i);
    addr_i = a[4:0];
    #3;
    chk(tag, int'(rd_data_o), exp);
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk_i);
    @(negedge clk_i); rst_i = 0;
    // R1 reset state
    rd("R1 ctrl", 'h00, 0);
    rd("R1 pri A", 'h04, 0);
    rd("R1 pri B", 'h08, 0);
    rd("R1 pri C", 'h0C, 0);
    rd("R1 en lo", 'h10, 'hFFFF);
    rd("R1 en hi", 'h14, 'h0FFF);
    chk("R1 no req", int'(irq_req_o), 0);
    // R3 fixed levels and R4 strict compare
    drive(28'h1, 0, 0);
    chk("R3 code lvl9", int'(irq_code_o), 'h320);
    chk("R3 level lvl9", int'(irq_level_o), 6);
    drive(28'h1, 6, 0);
    chk("R4 equal mask", int'(irq_req_o), 0);
    drive(28'h1, 5, 0);
    chk("R4 below", int'(irq_req_o), 1);
    drive(28'h7, 0, 0);
    chk("R9 highest fixed", int'(irq_code_o), 'h320);
    drive(28'h6, 3, 0);
    chk("R3 lvl11", int'(irq_code_o), 'h360);
    drive(28'h4, 1, 0);
    chk("R3 lvl13", int'(irq_code_o), 'h3A0);
    // R4 priority-0 peripheral never requested
    drive(28'h1 << 10, 0, 0);
    chk("R4 zero prio", int'(irq_req_o), 0);
    // R2/R8 write timing: field 3 of A drives source 10
    drive((28'h1 << 10) | 28'h1, 0, 0);
    @(negedge clk_i);
    wr_en_i = 1; addr_i = 5'h04; wdata_i = 16'h7000;
    #3;
    chk("R8 before edge", int'(irq_code_o), 'h320);
    @(negedge clk_i); wr_en_i = 0; #3;
    chk("R2 timer0 code", int'(irq_code_o), 'h400);
    chk("R2 timer0 level", int'(irq_level_o), 7);
    // R6 ties among DMA sources (C field 2)
    wr('h0C, 'h0500);
    drive((28'h1 << 5) | (28'h1 << 7), 0, 0);
    chk("R6 tie 5/7", int'(irq_code_o), 'h680);
    drive((28'h1 << 5) | (28'h1 << 9), 0, 0);
    chk("R6 tie 5/9", int'(irq_code_o), 'h6C0);
    // R5 block
    drive((28'h1 << 5) | (28'h1 << 9), 0, 1);
    chk("R5 block", int'(irq_req_o), 0);
    // R7 enable
    wr('h10, 'hFDFF);
    drive((28'h1 << 5) | (28'h1 << 9), 0, 0);
    chk("R7 disabled 9", int'(irq_code_o), 'h640);
    wr('h14, 'h0FF7);
    wr('h08, 'h00A0);
    drive(28'h1 << 19, 0, 0);
    chk("R7 disabled 19", int'(irq_req_o), 0);
    drive(28'h1 << 20, 0, 0);
    chk("R2 serial B1", int'(irq_code_o), 'h540);
    // R10 held pending keeps request
    repeat (20) @(negedge clk_i);
    #3;
    chk("R10 still raised", int'(irq_req_o), 1);
    // R11 unmapped writes
    wr('h18, 'hFFFF);
    wr('h05, 'h0000);
    rd("R11 read 18", 'h18, 0);
    rd("R11 A kept", 'h04, 'h7000);
    wr('h00, 'h1234);
    rd("R8 ctrl readback", 'h00, 'h1234);
    wr('h10, 'hFFFF);
    wr('h14, 'h0FFF);
    // Random phase, compared every cycle by the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk_i);
      pend_i  = $urandom & $urandom & $urandom;
      mask_i  = 4'($urandom);
      block_i = ($urandom % 8) == 0;
      addr_i  = 5'($urandom);
      if (($urandom % 4) == 0) addr_i = {3'($urandom % 6), 2'b00};
      wr_en_i = ($urandom % 5) == 0;
      wdata_i = 16'($urandom);
    end
    @(negedge clk_i); wr_en_i = 0;
    @(negedge clk_i);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule